// File: doc/BRIEF.md
# Byte-Addressed Serial Memory Target Front End

This block is the bus-facing half of a small serial memory. It watches the two-wire clock and data lines, using the system clock to oversample them. It finds bus conditions, decodes the device address byte and runs the byte-level protocol. The storage itself sits outside, behind a narrow byte port. That port carries a write strobe with a data byte, a read strobe with a returned byte, one shared word pointer and a flag that selects the protection-register path instead of the main array.

The data line is open-drain: `sda_oe` high pulls the wire low, and low releases it. A write transfer is made up of three parts: the device address, one word-address byte that loads the pointer, and then any number of data bytes. Each data byte is stored at the pointer, and the pointer then steps by one. A read transfer streams bytes from the pointer and steps it after each byte. It ends when the controller answers a byte with a not-acknowledge. A read at a chosen word is done by sending the write-form address and the word address, then a repeated START and the read-form address. The storage array is expected to return data for `mem_addr_o` combinationally on `mem_rdata_i`.

Top module: `i2c_mem_target`

## Requirements
- R1: While reset is held and right after it, `sda_oe`, `mem_wr_o`, `mem_rd_o` and `prot_sel_o` are all low.
- R2: The block only acts after a START, which is SDA falling while SCL is high. Bytes clocked before any START, or after a STOP (SDA rising while SCL is high), get no acknowledge and cause no write. A STOP returns the block to idle.
- R3: The address byte is taken MSB first. Bits 7:4 equal to 1010 and bits 3:1 equal to `strap_i` select normal memory. A selected device pulls SDA low for the whole of the ninth SCL high phase. Any other address gets no acknowledge, and the following bytes of that transfer are neither acknowledged nor stored.
- R4: Bits 7:4 equal to 0110 with matching strap bits also get an acknowledge, and `prot_sel_o` is then high for the rest of the transfer. `prot_sel_o` drops at STOP.
- R5: After a write-form address (bit 0 = 0), the first byte loads the word pointer. Each later byte is acknowledged and gives exactly one single-cycle `mem_wr_o` pulse, with the byte on `mem_wdata_o` and the pointer on `mem_addr_o`. The pointer then steps by one and wraps from 255 to 0.
- R6: After a read-form address (bit 0 = 1), the block sends the byte at the pointer, MSB first, and steps the pointer. A controller acknowledge (SDA low in the ninth clock) makes it send the next byte. A read with no preceding word address starts from wherever the pointer was left.
- R7: After a controller not-acknowledge in read mode, the block releases SDA and stays silent, neither driving nor acknowledging, until the next STOP or START.
- R8: A repeated START in the middle of a transfer restarts address decoding and keeps the pointer.
- R9: The block changes `sda_oe` only while SCL is low. The level it drives stays constant over each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_oe | output | 1 | High pulls the data line low; low releases it |
| strap_i | input | 3 | Board strap giving this device's address bits 3:1 |
| mem_addr_o | output | 8 | Current word pointer presented to the storage |
| mem_wr_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Byte to store while `mem_wr_o` is high |
| mem_rd_o | output | 1 | One-cycle strobe in the cycle the block takes `mem_rdata_i` |
| mem_rdata_i | input | 8 | Storage contents at `mem_addr_o` |
| prot_sel_o | output | 1 | High when the protection-register prefix matched |

## Verification
A change on a bus pin passes through two synchronizer flops, and the edge detector sees it on the third clock edge. Any response on `sda_oe` therefore follows an SCL fall by about three system clocks, and a write strobe follows the SCL fall that closes the byte by the same amount. The bench moves SCL only in quarter-bit steps of five clocks. It changes SDA five clocks after each SCL fall and reads the line in the middle of the SCL high phase. Every sample is thus taken long after the result is due and long before it may change again. Stored bytes, strobe counts and the pointer are checked only after the STOP of each transfer, against a model kept in the bench.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 3;
  localparam int CODE_W  = BYTE_W - STRAP_W - 1;
  localparam int BIT_CW  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK,
    ST_HOLD
  } tgt_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_WORD,
    PH_DATA
  } byte_role_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain[STAGES-2:0], d_i};
  end

  // idle bus level is high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= chain_n;
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic scl_hi,
  output logic start_det,
  output logic stop_det
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  =  scl_s & ~scl_q;
    scl_fall  = ~scl_s &  scl_q;
    scl_hi    =  scl_s &  scl_q;
    start_det =  scl_hi & sda_q & ~sda_s;
    stop_det  =  scl_hi & ~sda_q & sda_s;
  end

endmodule

// File: rtl/i2c_addr_decode.sv
module i2c_addr_decode
  import i2c_mem_pkg::*;
#(
  parameter logic [CODE_W-1:0] MEM_CODE  = 4'b1010,
  parameter logic [CODE_W-1:0] PROT_CODE = 4'b0110
) (
  input  logic [BYTE_W-1:0]  addr_byte,
  input  logic [STRAP_W-1:0] strap,
  output logic               hit_mem,
  output logic               hit_prot
);

  logic [CODE_W-1:0]  code;
  logic [STRAP_W-1:0] dev;
  logic               dev_ok;

  always_comb begin
    code     = addr_byte[BYTE_W-1 -: CODE_W];
    dev      = addr_byte[STRAP_W:1];
    dev_ok   = (dev == strap);
    hit_mem  = dev_ok && (code == MEM_CODE);
    hit_prot = dev_ok && (code == PROT_CODE);
  end

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] MEM_CODE    = 4'b1010,
  parameter logic [CODE_W-1:0] PROT_CODE   = 4'b0110
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [BYTE_W-1:0]  mem_addr_o,
  output logic               mem_wr_o,
  output logic [BYTE_W-1:0]  mem_wdata_o,
  output logic               mem_rd_o,
  input  logic [BYTE_W-1:0]  mem_rdata_i,
  output logic               prot_sel_o
);

  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

  // ---- line synchronizers, one per bus wire ----
  logic [1:0] line_raw;
  logic [1:0] line_s;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (line_raw[g]),
      .q_o   (line_s[g])
    );
  end

  logic scl_rise, scl_fall, scl_hi, start_det, stop_det;

  i2c_cond_detect i_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (line_s[0]),
    .sda_s     (line_s[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .scl_hi    (scl_hi),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  // ---- state registers ----
  tgt_state_t        state,  state_n;
  byte_role_t        role,   role_n;
  logic [BIT_CW-1:0] cnt,    cnt_n;
  logic [BYTE_W-1:0] sh,     sh_n;
  logic [BYTE_W-1:0] ptr,    ptr_n;
  logic [BYTE_W-1:0] wdat,   wdat_n;
  logic              full,   full_n;
  logic              rd_dir, rd_dir_n;
  logic              prot,   prot_n;
  logic              wr_q,   wr_n;
  logic              ack_ok, ack_ok_n;
  logic              rd_pulse;
  logic              hit_mem, hit_prot;

  i2c_addr_decode #(.MEM_CODE(MEM_CODE), .PROT_CODE(PROT_CODE)) i_dec (
    .addr_byte (sh),
    .strap     (strap_i),
    .hit_mem   (hit_mem),
    .hit_prot  (hit_prot)
  );

  // ---- next-state logic ----
  always_comb begin
    state_n  = state;
    role_n   = role;
    cnt_n    = cnt;
    sh_n     = sh;
    ptr_n    = ptr;
    wdat_n   = wdat;
    full_n   = full;
    rd_dir_n = rd_dir;
    prot_n   = prot;
    ack_ok_n = ack_ok;
    wr_n     = 1'b0;
    rd_pulse = 1'b0;

    // pointer steps in the cycle after a write strobe
    if (wr_q) ptr_n = ptr + BYTE_W'(1);

    if (stop_det) begin
      state_n = ST_IDLE;
      prot_n  = 1'b0;
    end else if (start_det) begin
      state_n = ST_RX;
      role_n  = PH_ADDR;
      cnt_n   = '0;
      full_n  = 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise) begin
            sh_n  = {sh[BYTE_W-2:0], line_s[1]};
            cnt_n = cnt + BIT_CW'(1);
            if (cnt == LAST_BIT) full_n = 1'b1;
          end else if (scl_fall && full) begin
            full_n = 1'b0;
            cnt_n  = '0;
            unique case (role)
              PH_ADDR: begin
                if (hit_mem || hit_prot) begin
                  state_n  = ST_RXACK;
                  rd_dir_n = sh[0];
                  prot_n   = hit_prot;
                end else begin
                  state_n  = ST_HOLD;
                end
              end
              PH_WORD: begin
                ptr_n   = sh;
                role_n  = PH_DATA;
                state_n = ST_RXACK;
              end
              default: begin
                wr_n    = 1'b1;
                wdat_n  = sh;
                state_n = ST_RXACK;
              end
            endcase
          end
        end
        ST_RXACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (role == PH_ADDR && rd_dir) begin
              rd_pulse = 1'b1;
              sh_n     = mem_rdata_i;
              ptr_n    = ptr + BYTE_W'(1);
              state_n  = ST_TX;
            end else begin
              if (role == PH_ADDR) role_n = PH_WORD;
              state_n = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              state_n = ST_TXACK;
            end else begin
              sh_n  = {sh[BYTE_W-2:0], 1'b0};
              cnt_n = cnt + BIT_CW'(1);
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            ack_ok_n = ~line_s[1];
          end else if (scl_fall) begin
            cnt_n = '0;
            if (ack_ok) begin
              rd_pulse = 1'b1;
              sh_n     = mem_rdata_i;
              ptr_n    = ptr + BYTE_W'(1);
              state_n  = ST_TX;
            end else begin
              state_n  = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // ---- register process ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      role   <= PH_ADDR;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      wdat   <= '0;
      full   <= 1'b0;
      rd_dir <= 1'b0;
      prot   <= 1'b0;
      wr_q   <= 1'b0;
      ack_ok <= 1'b0;
    end else begin
      state  <= state_n;
      role   <= role_n;
      cnt    <= cnt_n;
      sh     <= sh_n;
      ptr    <= ptr_n;
      wdat   <= wdat_n;
      full   <= full_n;
      rd_dir <= rd_dir_n;
      prot   <= prot_n;
      wr_q   <= wr_n;
      ack_ok <= ack_ok_n;
    end
  end

  // ---- outputs ----
  assign sda_oe      = (state == ST_RXACK) || ((state == ST_TX) && !sh[BYTE_W-1]);
  assign mem_addr_o  = ptr;
  assign mem_wr_o    = wr_q;
  assign mem_wdata_o = wdat;
  assign mem_rd_o    = rd_pulse;
  assign prot_sel_o  = prot;

  // ---- assertions ----
  assert_oe_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hi |=> $stable(sda_oe));

  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE));

  assert_prot_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !prot_sel_o);

  assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |=> !mem_wr_o);

  assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  assert_hold_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !start_det && !stop_det) |=> (state == ST_HOLD));

  assert_ack_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RXACK && $past(state) != ST_RXACK) |-> $past(full));

endmodule

// File: tb/test_i2c_mem_target.sv
`timescale 1ns/1ps
module test_i2c_mem_target;

  localparam int Q = 5;

  logic       clk;
  logic       rst_n;
  logic       scl_drv;
  logic       sda_drv;
  logic [2:0] strap;
  logic       sda_oe;
  logic [7:0] mem_addr_o;
  logic       mem_wr_o;
  logic [7:0] mem_wdata_o;
  logic       mem_rd_o;
  logic [7:0] mem_rdata;
  logic       prot_sel_o;
  logic       sda_bus;

  logic [7:0] mem      [256];
  logic [7:0] prot_mem [256];

  int total, bad, wr_cnt, oe_cnt, glitch;
  bit done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign sda_bus   = sda_drv & ~sda_oe;
  assign mem_rdata = prot_sel_o ? prot_mem[mem_addr_o] : mem[mem_addr_o];

  i2c_mem_target i_i2c_mem_target (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_drv),
    .sda_i       (sda_bus),
    .sda_oe      (sda_oe),
    .strap_i     (strap),
    .mem_addr_o  (mem_addr_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rd_o    (mem_rd_o),
    .mem_rdata_i (mem_rdata),
    .prot_sel_o  (prot_sel_o)
  );

  // storage model written through the block's strobe
  always @(posedge clk) begin
    if (mem_wr_o) begin
      wr_cnt = wr_cnt + 1;
      if (prot_sel_o) prot_mem[mem_addr_o] = mem_wdata_o;
      else            mem[mem_addr_o]      = mem_wdata_o;
    end
    if (sda_oe) oe_cnt = oe_cnt + 1;
  end

  function automatic logic [7:0] mem_init(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  function automatic logic [7:0] prot_init(input int i);
    return ~8'(i);
  endfunction

  task automatic q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_xfer(input logic b, output logic seen);
    logic a0, a1;
    scl_drv = 1'b0; q(Q);
    sda_drv = b;    q(Q);
    scl_drv = 1'b1; q(2);
    a0 = sda_bus;   q(Q-2);
    seen = sda_bus; q(Q-1);
    a1 = sda_bus;   q(1);
    if (a0 !== a1) glitch++;
  endtask

  task automatic do_start();
    scl_drv = 1'b0; q(Q);
    sda_drv = 1'b1; q(Q);
    scl_drv = 1'b1; q(Q);
    sda_drv = 1'b0; q(Q);
  endtask

  task automatic do_stop();
    scl_drv = 1'b0; q(Q);
    sda_drv = 1'b0; q(Q);
    scl_drv = 1'b1; q(Q);
    sda_drv = 1'b1; q(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      d[i] = s;
    end
    bit_xfer(~give_ack, s);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    int         eptr, w0, o0;
    logic [7:0] wv [3];

    for (int i = 0; i < 256; i++) begin
      mem[i]      = mem_init(i);
      prot_mem[i] = prot_init(i);
    end
    scl_drv = 1'b1;
    sda_drv = 1'b1;
    strap   = 3'b101;
    rst_n   = 1'b0;
    q(2);
    // R1: outputs quiet while reset is held
    chk(sda_oe == 1'b0 && mem_wr_o == 1'b0, "R1", {sda_oe, mem_wr_o}, 0);
    q(3);
    rst_n = 1'b1;
    q(4);
    chk(sda_oe == 1'b0,     "R1", sda_oe, 0);
    chk(mem_wr_o == 1'b0,   "R1", mem_wr_o, 0);
    chk(mem_rd_o == 1'b0,   "R1", mem_rd_o, 0);
    chk(prot_sel_o == 1'b0, "R1", prot_sel_o, 0);

    // R2: a matching address clocked without a START is ignored
    o0 = oe_cnt;
    send_byte(8'hAA, ack);
    chk(!ack, "R2", ack, 0);
    chk(oe_cnt == o0, "R2", oe_cnt - o0, 0);
    do_stop();

    // R3 / R4: every address byte against strap 101
    eptr = 0;
    for (int a = 0; a < 256; a++) begin
      logic exp_ack, exp_prot;
      exp_ack  = ((a >> 4) == 4'hA || (a >> 4) == 4'h6) && (((a >> 1) & 7) == 5);
      exp_prot = (a >> 4) == 4'h6;
      do_start();
      send_byte(8'(a), ack);
      chk(ack == exp_ack, "R3", ack, exp_ack);
      if (ack) begin
        chk(prot_sel_o == exp_prot, "R4", prot_sel_o, exp_prot);
        if (a[0]) begin
          recv_byte(1'b0, d);
          chk(d == (exp_prot ? prot_init(eptr) : mem_init(eptr)), "R6", d,
              exp_prot ? prot_init(eptr) : mem_init(eptr));
          eptr = (eptr + 1) & 255;
        end
      end
      do_stop();
      chk(prot_sel_o == 1'b0, "R4", prot_sel_o, 0);
    end
    chk(wr_cnt == 0, "R3", wr_cnt, 0);

    // R3: every strap value against every device field
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int f = 0; f < 8; f++) begin
        do_start();
        send_byte({4'hA, 3'(f), 1'b0}, ack);
        chk(ack == (f == s), "R3", ack, f == s);
        do_stop();
      end
    end
    strap = 3'b101;

    // R5: word address then three data bytes
    w0 = wr_cnt;
    for (int i = 0; i < 3; i++) wv[i] = 8'(8'h11 * (i + 1) + 8'h80);
    do_start();
    send_byte(8'hAA, ack); chk(ack, "R5", ack, 1);
    send_byte(8'h40, ack); chk(ack, "R5", ack, 1);
    for (int i = 0; i < 3; i++) begin
      send_byte(wv[i], ack);
      chk(ack, "R5", ack, 1);
    end
    do_stop();
    chk(wr_cnt - w0 == 3, "R5", wr_cnt - w0, 3);
    for (int i = 0; i < 3; i++) chk(mem[8'h40 + i] == wv[i], "R5", mem[8'h40 + i], wv[i]);

    // R5: pointer wraps from 255 to 0
    do_start();
    send_byte(8'hAA, ack);
    send_byte(8'hFF, ack);
    send_byte(8'hA5, ack);
    send_byte(8'h5A, ack);
    do_stop();
    chk(mem[255] == 8'hA5, "R5", mem[255], 8'hA5);
    chk(mem[0] == 8'h5A,   "R5", mem[0], 8'h5A);

    // R8 / R6: word address, repeated START, sequential read
    do_start();
    send_byte(8'hAA, ack);
    send_byte(8'h40, ack);
    do_start();
    send_byte(8'hAB, ack);
    chk(ack, "R8", ack, 1);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i != 2, d);
      chk(d == wv[i], "R6", d, wv[i]);
    end
    do_stop();

    // R6: read with no word address continues from the pointer
    do_start();
    send_byte(8'hAB, ack);
    recv_byte(1'b0, d);
    chk(d == mem_init(8'h43), "R6", d, mem_init(8'h43));
    do_stop();

    // R7: after a NACK the block stays silent until STOP
    do_start();
    send_byte(8'hAB, ack);
    recv_byte(1'b0, d);
    o0 = oe_cnt;
    w0 = wr_cnt;
    send_byte(8'hAA, ack);
    chk(!ack, "R7", ack, 0);
    send_byte(8'h00, ack);
    chk(oe_cnt == o0, "R7", oe_cnt - o0, 0);
    chk(wr_cnt == w0, "R7", wr_cnt - w0, 0);
    do_stop();
    do_start();
    send_byte(8'hAA, ack);
    chk(ack, "R7", ack, 1);
    do_stop();

    // R4: protection path write and read back
    do_start();
    send_byte(8'h6A, ack); chk(ack, "R4", ack, 1);
    send_byte(8'h05, ack);
    send_byte(8'h5C, ack);
    chk(prot_sel_o == 1'b1, "R4", prot_sel_o, 1);
    do_stop();
    chk(prot_mem[5] == 8'h5C, "R4", prot_mem[5], 8'h5C);
    chk(mem[5] == mem_init(5), "R4", mem[5], mem_init(5));
    do_start();
    send_byte(8'h6A, ack);
    send_byte(8'h05, ack);
    do_start();
    send_byte(8'h6B, ack);
    recv_byte(1'b0, d);
    chk(d == 8'h5C, "R4", d, 8'h5C);
    do_stop();

    // R3: mismatched strap -> no acks, no writes
    w0 = wr_cnt;
    do_start();
    send_byte(8'hA2, ack); chk(!ack, "R3", ack, 0);
    send_byte(8'h10, ack); chk(!ack, "R3", ack, 0);
    send_byte(8'h77, ack); chk(!ack, "R3", ack, 0);
    do_stop();
    chk(wr_cnt == w0, "R3", wr_cnt - w0, 0);

    // R2: bytes after a STOP are ignored
    do_start();
    send_byte(8'hAA, ack);
    send_byte(8'h20, ack);
    do_stop();
    w0 = wr_cnt;
    send_byte(8'h99, ack);
    chk(!ack, "R2", ack, 0);
    do_stop();
    chk(wr_cnt == w0, "R2", wr_cnt - w0, 0);

    // R9: driven level never moved during an SCL high phase
    chk(glitch == 0, "R9", glitch, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule